// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit with HI/LO Result Registers

This block is a background arithmetic unit for a processor pipeline. A single-cycle `start` pulse hands it an operation code and two 32-bit operands. The unit then runs a signed or unsigned multiply, or a signed or unsigned divide, over many cycles while the rest of the pipeline keeps moving. The answer lands in two dedicated result registers, HI and LO, and no general-purpose register is written. Multiplication produces a 64-bit product split across HI and LO. Division leaves the quotient in LO and the remainder in HI.

The issuing pipeline reads HI or LO through a read request. While a computation is still running, the unit asserts `stall` so that the reader waits. Move-to writes load either register directly from a supplied word. A new `start` while the unit is busy abandons the running operation. No operation ever reports overflow or traps, and that includes a zero divisor.

Top module: `muldiv_unit`

## Requirements
- R1: Operation code 2'b00 (signed multiply) leaves the upper 32 bits of the two's-complement 64-bit product in HI and the lower 32 bits in LO.
- R2: Operation code 2'b01 (unsigned multiply) leaves the upper and lower halves of the unsigned 64-bit product in HI and LO respectively.
- R3: Operation code 2'b10 (signed divide) leaves the quotient, truncated toward zero, in LO. It leaves in HI a remainder whose sign matches the dividend.
- R4: Operation code 2'b11 (unsigned divide) leaves the unsigned quotient in LO and the unsigned remainder in HI.
- R5: A divide with a zero divisor, signed or unsigned, completes normally with all ones in LO and the unmodified dividend in HI.
- R6: `busy` rises on the clock edge that samples `start` and stays high for exactly 33 cycles. HI and LO take their results on the edge where `busy` falls.
- R7: `rd_data` always shows HI when `rd_sel`=1 and LO when `rd_sel`=0. `stall` is high exactly when `rd_req` is high while `busy` is high.
- R8: With `wr_en` high, the next edge loads `wr_data` into HI (`wr_sel`=1) or LO (`wr_sel`=0). The other register is left alone. If this coincides with a completing operation, the operation's results win.
- R9: A `start` while `busy` is high discards the running operation. Its results are never written, and the new operation takes the full 33 cycles.
- R10: After reset, HI and LO read zero and `busy` is low.
- R11: The signed divide of 0x80000000 by 0xFFFFFFFF completes without any error indication, giving LO=0x80000000 and HI=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation this cycle |
| op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa | input | 32 | Multiplicand / dividend |
| opb | input | 32 | Multiplier / divisor |
| busy | output | 1 | Operation in progress |
| wr_en | input | 1 | Move-to write enable |
| wr_sel | input | 1 | Move-to target: 1 HI, 0 LO |
| wr_data | input | 32 | Move-to value |
| rd_req | input | 1 | Move-from request |
| rd_sel | input | 1 | Move-from source: 1 HI, 0 LO |
| rd_data | output | 32 | Selected HI or LO value |
| stall | output | 1 | Read must wait for completion |

## Verification
The hardest cases to reach from the ports are a move-to write or a new `start` that lands on the exact edge where an operation completes, or a few cycles before it. The stimulus issues an operation and then sweeps a move-to write, and separately a second `start`, across a range of cycle offsets around the completion edge. A behavioural model that counts cycles decides which value should survive each time. Reads issued right after `start` exercise the stall path. The signed corner operands (most negative value, minus one, zero divisor) are driven on purpose, and a random mix covers the rest.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MULS = 2'b00,
    OP_MULU = 2'b01,
    OP_DIVS = 2'b10,
    OP_DIVU = 2'b11
  } md_op_e;
endpackage

// File: rtl/mul_engine.sv
module mul_engine #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [WIDTH-1:0]   a_mag,
  input  logic [WIDTH-1:0]   b_mag,
  output logic [2*WIDTH-1:0] prod
);
  logic [2*WIDTH-1:0] prod_q;
  logic [WIDTH-1:0]   mcand_q;
  logic [WIDTH:0]     upper_sum;

  // one shift-add step: add multiplicand into the upper half when the low bit is set
  always_comb begin
    upper_sum = {1'b0, prod_q[2*WIDTH-1:WIDTH]} + (prod_q[0] ? {1'b0, mcand_q} : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q  <= '0;
      mcand_q <= '0;
    end else if (load) begin
      prod_q  <= {{WIDTH{1'b0}}, b_mag};
      mcand_q <= a_mag;
    end else if (step) begin
      prod_q  <= {upper_sum, prod_q[WIDTH-1:1]};
    end
  end

  assign prod = prod_q;
endmodule

// File: rtl/div_engine.sv
module div_engine #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] dvd_mag,
  input  logic [WIDTH-1:0] dvs_mag,
  output logic [WIDTH-1:0] quo,
  output logic [WIDTH-1:0] rem
);
  logic [WIDTH-1:0] rem_q, quo_q, dvs_q;
  logic [WIDTH:0]   shifted, trial;
  logic             fits;

  // restoring step: bring down one dividend bit, subtract if it fits
  always_comb begin
    shifted = {rem_q, quo_q[WIDTH-1]};
    trial   = shifted - {1'b0, dvs_q};
    fits    = shifted >= {1'b0, dvs_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= dvd_mag;
      dvs_q <= dvs_mag;
    end else if (step) begin
      rem_q <= fits ? trial[WIDTH-1:0] : shifted[WIDTH-1:0];
      quo_q <= {quo_q[WIDTH-2:0], fits};
    end
  end

  assign quo = quo_q;
  assign rem = rem_q;

  // R4 partial remainder always below a nonzero divisor
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dvs_q != '0) |-> (rem_q < dvs_q));
endmodule

// File: rtl/hilo_regs.sv
module hilo_regs #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fin,
  input  logic [WIDTH-1:0] res_hi,
  input  logic [WIDTH-1:0] res_lo,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);
  logic [WIDTH-1:0] hi_q, lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (fin) begin
      hi_q <= res_hi;
      lo_q <= res_lo;
    end else if (wr_en) begin
      if (wr_sel) hi_q <= wr_data;
      else        lo_q <= wr_data;
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;

  // R8 registers hold when neither a result nor a move-to arrives
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fin && !wr_en) |=> ($stable(hi_q) && $stable(lo_q)));

  // R8 a move-to leaves the other register untouched
  other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fin && wr_en && wr_sel) |=> $stable(lo_q));
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic             busy,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_req,
  input  logic             rd_sel,
  output logic [WIDTH-1:0] rd_data,
  output logic             stall
);
  import muldiv_pkg::*;

  localparam int CW = $clog2(WIDTH) + 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH);

  function automatic logic [WIDTH-1:0] magnitude(input logic [WIDTH-1:0] v, input logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [2*WIDTH-1:0] signed_product(input logic [2*WIDTH-1:0] p, input logic neg);
    return neg ? (~p + 1'b1) : p;
  endfunction

  logic             busy_q, is_div_q, neg_q, rneg_q, dz_q;
  logic [CW-1:0]    cnt_q;
  logic [WIDTH-1:0] dvd_q;
  logic             signed_op, a_neg, b_neg;
  logic             step_w, fin_w;
  logic [2*WIDTH-1:0] mul_prod, mul_fixed;
  logic [WIDTH-1:0] div_quo, div_rem;
  logic [WIDTH-1:0] res_hi, res_lo, hi, lo;

  assign signed_op = (op == OP_MULS) || (op == OP_DIVS);
  assign a_neg     = signed_op & opa[WIDTH-1];
  assign b_neg     = signed_op & opb[WIDTH-1];

  // named internal events
  assign step_w = busy_q & ~start & (cnt_q != LAST);
  assign fin_w  = busy_q & ~start & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      is_div_q <= 1'b0;
      neg_q    <= 1'b0;
      rneg_q   <= 1'b0;
      dz_q     <= 1'b0;
      dvd_q    <= '0;
    end else if (start) begin
      busy_q   <= 1'b1;
      cnt_q    <= '0;
      is_div_q <= op[1];
      neg_q    <= a_neg ^ b_neg;
      rneg_q   <= a_neg;
      dz_q     <= (opb == '0);
      dvd_q    <= opa;
    end else if (busy_q) begin
      if (fin_w) busy_q <= 1'b0;
      else       cnt_q  <= cnt_q + 1'b1;
    end
  end

  mul_engine #(.WIDTH(WIDTH)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start & ~op[1]),
    .step  (step_w & ~is_div_q),
    .a_mag (magnitude(opa, a_neg)),
    .b_mag (magnitude(opb, b_neg)),
    .prod  (mul_prod)
  );

  div_engine #(.WIDTH(WIDTH)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start & op[1]),
    .step    (step_w & is_div_q),
    .dvd_mag (magnitude(opa, a_neg)),
    .dvs_mag (magnitude(opb, b_neg)),
    .quo     (div_quo),
    .rem     (div_rem)
  );

  // sign fix-up after magnitude iteration
  always_comb begin
    mul_fixed = signed_product(mul_prod, neg_q);
    if (!is_div_q) begin
      res_hi = mul_fixed[2*WIDTH-1:WIDTH];
      res_lo = mul_fixed[WIDTH-1:0];
    end else if (dz_q) begin
      res_hi = dvd_q;
      res_lo = '1;
    end else begin
      res_hi = magnitude(div_rem, rneg_q);
      res_lo = magnitude(div_quo, neg_q);
    end
  end

  hilo_regs #(.WIDTH(WIDTH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .fin     (fin_w),
    .res_hi  (res_hi),
    .res_lo  (res_lo),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .hi      (hi),
    .lo      (lo)
  );

  assign busy    = busy_q;
  assign stall   = rd_req & busy_q;
  assign rd_data = rd_sel ? hi : lo;

  // R6 busy rises on the edge that samples start
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);

  // R6 an iteration step never ends the operation
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_w |=> busy_q);

  // R6 completion drops busy
  fin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_w |=> !busy_q);

  // R9 a restart while busy begins the count afresh
  abort_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy_q) |=> (cnt_q == '0));
endmodule

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] opa = '0, opb = '0;
  logic        busy;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_req = 1'b0, rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        stall;

  int checks = 0;
  int errors = 0;
  string tag_drv = "R1";

  always #5 clk = ~clk;

  muldiv_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .busy(busy), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_req(rd_req), .rd_sel(rd_sel), .rd_data(rd_data), .stall(stall)
  );

  // behavioural reference
  logic [31:0] m_hi, m_lo, p_hi, p_lo;
  bit          m_busy;
  int          m_left;
  string       hi_tag, lo_tag, p_tag;

  task automatic ref_calc(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                          output logic [31:0] h, output logic [31:0] l);
    longint sa, sb, q, r;
    longint unsigned ua, ub, up;
    logic [63:0] v;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'b0, a};
    ub = {32'b0, b};
    case (o)
      2'b00: begin v = 64'(sa * sb); h = v[63:32]; l = v[31:0]; end
      2'b01: begin up = ua * ub; v = up; h = v[63:32]; l = v[31:0]; end
      default: begin
        if (b == 0) begin
          h = a; l = '1;
        end else if (o == 2'b10) begin
          q = sa / sb; r = sa % sb;
          l = q[31:0]; h = r[31:0];
        end else begin
          up = ua / ub; l = up[31:0];
          up = ua % ub; h = up[31:0];
        end
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_left = 0; m_hi = '0; m_lo = '0;
      hi_tag = "R10"; lo_tag = "R10";
    end else begin
      if (wr_en) begin
        if (wr_sel) begin m_hi = wr_data; hi_tag = "R8"; end
        else begin m_lo = wr_data; lo_tag = "R8"; end
      end
      if (start) begin
        ref_calc(op, opa, opb, p_hi, p_lo);
        p_tag = tag_drv;
        m_busy = 1; m_left = 33;
      end else if (m_busy) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_hi = p_hi; m_lo = p_lo;
          hi_tag = p_tag; lo_tag = p_tag;
          m_busy = 0;
        end
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (busy !== m_busy) begin
        errors++;
        $display("FAIL R6 busy actual %0b expected %0b", busy, m_busy);
      end
      checks++;
      if (stall !== (rd_req && m_busy)) begin
        errors++;
        $display("FAIL R7 stall actual %0b expected %0b", stall, rd_req && m_busy);
      end
      if (rd_req && !m_busy) begin
        checks++;
        if (rd_data !== (rd_sel ? m_hi : m_lo)) begin
          errors++;
          $display("FAIL %s/R7 %s actual %h expected %h", rd_sel ? hi_tag : lo_tag,
                   rd_sel ? "HI" : "LO", rd_data, rd_sel ? m_hi : m_lo);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog expired actual busy=%0b expected run complete", busy);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic issue(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b, input string t);
    @(negedge clk); #1;
    tag_drv = t; start = 1'b1; op = o; opa = a; opb = b;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic read_one(input logic sel);
    @(negedge clk); #1;
    rd_req = 1'b1; rd_sel = sel;
    @(negedge clk);
    while (stall) @(negedge clk);
    #1 rd_req = 1'b0;
  endtask

  task automatic move_to(input logic sel, input logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic run(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b, input string t);
    issue(o, a, b, t);
    read_one(1'b0);
    read_one(1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R10 reset values
    read_one(1'b0);
    read_one(1'b1);
    // R1 signed multiply
    run(2'b00, 32'hFFFF_FFFD, 32'd7, "R1");
    run(2'b00, 32'h8000_0000, 32'h8000_0000, "R1");
    run(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1");
    // R2 unsigned multiply
    run(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
    run(2'b01, 32'd12345, 32'd67890, "R2");
    // R3 signed divide
    run(2'b10, 32'hFFFF_FFF9, 32'd2, "R3");
    run(2'b10, 32'd7, 32'hFFFF_FFFE, "R3");
    run(2'b10, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R3");
    // R4 unsigned divide
    run(2'b11, 32'hFFFF_FFFF, 32'd3, "R4");
    run(2'b11, 32'd100, 32'd7, "R4");
    run(2'b11, 32'd5, 32'hFFFF_FFFF, "R4");
    // R5 zero divisor
    run(2'b10, 32'hFFFF_FFFB, 32'd0, "R5");
    run(2'b11, 32'd9, 32'd0, "R5");
    // R11 most negative over minus one
    run(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, "R11");
    // R8 plain move-to
    move_to(1'b1, 32'hDEAD_BEEF);
    move_to(1'b0, 32'h1234_5678);
    read_one(1'b1);
    read_one(1'b0);
    // R8 move-to swept around completion
    for (int k = 28; k < 36; k++) begin
      issue(2'b01, 32'd1000 + k, 32'd3, "R8");
      repeat (k) @(negedge clk);
      move_to(k[0], 32'hA5A5_0000 + k);
      read_one(1'b0);
      read_one(1'b1);
    end
    // R9 restart while busy at several offsets
    for (int k = 0; k < 34; k += 3) begin
      issue(2'b00, 32'd77, 32'd88, "R9");
      repeat (k) @(negedge clk);
      issue(2'b11, 32'd1000, 32'd7 + k, "R9");
      read_one(1'b0);
      read_one(1'b1);
    end
    // random mix over R1 to R4
    for (int i = 0; i < 40; i++) begin
      logic [1:0] o;
      o = 2'($urandom_range(0, 3));
      case (o)
        2'b00: run(o, $urandom, $urandom, "R1");
        2'b01: run(o, $urandom, $urandom, "R2");
        2'b10: run(o, $urandom, 32'($urandom_range(0, 4)) - 32'd2, "R3");
        default: run(o, $urandom, $urandom >> $urandom_range(0, 31), "R4");
      endcase
    end
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule